// File: doc/BRIEF.md
# Per-Slot Control Bit Serializer

This block walks through a control memory that holds one bit for every stream and channel pair of a switching frame. It sends those bits, one per bit period, on a single serial line that runs in step with the serial data streams. A frame is 8 streams by 32 channels, which gives 256 bits per frame. Within each channel period the eight bit positions carry the bits of streams 0 to 7 in turn. The line runs one whole channel period ahead of the data streams, so that outside circuitry, such as external tristate or gain control, has time to act before the channel it controls arrives.

A frame pulse aligns the internal slot counter. The block issues a read address one bit period before each slot, and the control memory returns the stored bit from its output register. The block does not write the memory. The stream count, the channel count and the lead in channels are all parameters.

Top module: `ctl_serializer`

## Requirements
- R1: Without further frame pulses the slot counter runs free over 256 slots. The output sequence therefore repeats every 256 bit clocks.
- R2: A stored 1 is sent as a high level on `ctl_out` and a stored 0 as a low level, with no inversion.
- R3: Slot index s = 8*c + (7-b) is the data-stream channel c, bit b, where bit 7 is sent first. During slot s the output carries the bit of stream s mod 8 for channel (s/8 + 1) mod 32. The memory address of a stream and channel pair is stream*32 + channel.
- R4: The bit for stream 0, channel 0 (address 0) goes out in slot 248, which is data channel 31, bit 7. The bit for stream 1, channel 0 (address 32) goes out in slot 249.
- R5: `frame_pulse` is sampled on a rising clock edge. The cycle after a sampled pulse is slot 0. A pulse in the middle of a frame realigns the counter at once.
- R6: In the cycle before slot s, `rd_addr` carries the address of the bit for slot s. This allows for a memory whose read data is registered by one clock.
- R7: `ctl_out` is low while `rst_n` is low, and it stays low after reset until the first frame pulse has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame alignment; the next cycle is slot 0 |
| rd_addr | output | 8 | Control memory read address, {stream, channel} |
| rd_data | input | 1 | Registered control memory read data |
| ctl_out | output | 1 | Serial control bit output |

## Verification
On every cycle the checker tracks the slot counter. It checks the step and the wrap of the counter, the realignment after a frame pulse, the lookahead address issued during a pulse, the address issued just before the stream 0, channel 0 slot, and the quiet output before alignment. Only the bench scenarios can show that the correct stored bit reaches the line in each slot with the correct polarity, including after random memory changes. The bench scenarios also cover the level during and right after an asynchronous reset and the repetition of the sequence over several frames without a pulse.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned CBS_STREAMS_DEF  = 8;
  localparam int unsigned CBS_CHANNELS_DEF = 32;
  localparam int unsigned CBS_LEAD_DEF     = 1;
endpackage

// File: rtl/cbs_reset_sync.sv
module cbs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cbs_slot_counter.sv
module cbs_slot_counter #(
  parameter int unsigned NUM_SLOTS = 256,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_next,
  output logic              synced_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic synced_d;

  // next-state
  always_comb begin
    if (frame_pulse) begin
      slot_next = '0;
    end else if (slot_q == LAST_SLOT) begin
      slot_next = '0;
    end else begin
      slot_next = slot_q + SLOT_W'(1);
    end
    synced_d = synced_q | frame_pulse;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      synced_q <= 1'b0;
    end else begin
      slot_q   <= slot_next;
      synced_q <= synced_d;
    end
  end
endmodule

// File: rtl/cbs_addr_map.sv
module cbs_addr_map #(
  parameter int unsigned NUM_STREAMS  = 8,
  parameter int unsigned NUM_CHANNELS = 32,
  parameter int unsigned LEAD         = 1,
  localparam int unsigned NUM_SLOTS   = NUM_STREAMS * NUM_CHANNELS,
  localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W      = $clog2(NUM_SLOTS)
) (
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr
);
  int unsigned stream_idx;
  int unsigned chan_idx;

  // Within a channel period the streams are interleaved, stream 0 first;
  // the channel is advanced by the lead so the line runs ahead of the data.
  always_comb begin
    stream_idx = int'(slot) % NUM_STREAMS;
    chan_idx   = ((int'(slot) / NUM_STREAMS) + LEAD) % NUM_CHANNELS;
    addr       = ADDR_W'(stream_idx * NUM_CHANNELS + chan_idx);
  end
endmodule

// File: rtl/cbs_out_stage.sv
module cbs_out_stage (
  input  logic synced,
  input  logic rd_data,
  output logic ctl_out
);
  // Memory output register doubles as the line register; gated low until aligned.
  assign ctl_out = synced & rd_data;
endmodule

// File: rtl/ctl_serializer.sv
module ctl_serializer #(
  parameter int unsigned NUM_STREAMS  = cbs_pkg::CBS_STREAMS_DEF,
  parameter int unsigned NUM_CHANNELS = cbs_pkg::CBS_CHANNELS_DEF,
  parameter int unsigned LEAD         = cbs_pkg::CBS_LEAD_DEF,
  localparam int unsigned NUM_SLOTS   = NUM_STREAMS * NUM_CHANNELS,
  localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data,
  output logic              ctl_out
);
  logic              rst_sync_n;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_next;
  logic              synced_q;

  cbs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbs_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_pulse (frame_pulse),
    .slot_q      (slot_q),
    .slot_next   (slot_next),
    .synced_q    (synced_q)
  );

  // Address for the next slot, one bit period early for the registered memory.
  cbs_addr_map #(
    .NUM_STREAMS  (NUM_STREAMS),
    .NUM_CHANNELS (NUM_CHANNELS),
    .LEAD         (LEAD)
  ) u_map (
    .slot (slot_next),
    .addr (rd_addr)
  );

  cbs_out_stage u_out (
    .synced  (synced_q),
    .rd_data (rd_data),
    .ctl_out (ctl_out)
  );
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int unsigned NUM_STREAMS  = 8,
  parameter int unsigned NUM_CHANNELS = 32,
  parameter int unsigned LEAD         = 1,
  localparam int unsigned NUM_SLOTS   = NUM_STREAMS * NUM_CHANNELS,
  localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W      = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_pulse,
  input logic [SLOT_W-1:0] slot_q,
  input logic              synced_q,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              ctl_out
);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(LEAD % NUM_CHANNELS);
  localparam logic [SLOT_W-1:0] PRE_S0_SLOT =
    SLOT_W'((((NUM_CHANNELS - (LEAD % NUM_CHANNELS)) % NUM_CHANNELS) * NUM_STREAMS
             + NUM_SLOTS - 1) % NUM_SLOTS);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_pulse && slot_q == LAST_SLOT) |=> slot_q == '0);

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_pulse && slot_q != LAST_SLOT) |=> slot_q == $past(slot_q) + SLOT_W'(1));

  assert_frame_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (slot_q == '0 && synced_q));

  assert_lookahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> rd_addr == FIRST_ADDR);

  assert_first_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_pulse && slot_q == PRE_S0_SLOT) |-> rd_addr == '0);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_q |-> !ctl_out);
endmodule

bind ctl_serializer cbs_checker #(
  .NUM_STREAMS  (NUM_STREAMS),
  .NUM_CHANNELS (NUM_CHANNELS),
  .LEAD         (LEAD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .frame_pulse (frame_pulse),
  .slot_q      (slot_q),
  .synced_q    (synced_q),
  .rd_addr     (rd_addr),
  .ctl_out     (ctl_out)
);

// File: tb/ctl_serializer_test.sv
module ctl_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 256;

  logic       clk;
  logic       rst_n;
  logic       frame_pulse;
  logic [7:0] rd_addr;
  logic       rd_data;
  logic       ctl_out;

  logic mem [SLOTS];
  int   compared;
  int   mismatched;
  bit   mon_on;
  bit   done;
  string tag;
  int   m_pos;
  bit   m_sync;
  bit   exp_q;

  ctl_serializer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .ctl_out     (ctl_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int addr_of(int slot);
    return (slot % 8) * 32 + ((slot / 8) + 1) % 32;
  endfunction

  function automatic int next_of(int pos, bit fp);
    return fp ? 0 : (pos + 1) % SLOTS;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // registered control memory model
  always @(posedge clk) rd_data <= mem[rd_addr];

  // bench reference model of slot position and expected line value
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos  <= 0;
      m_sync <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      m_pos  <= next_of(m_pos, frame_pulse);
      m_sync <= m_sync | frame_pulse;
      exp_q  <= mem[addr_of(next_of(m_pos, frame_pulse))];
    end
  end

  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (m_sync && (m_pos == 248 || m_pos == 249))
        check("R4", int'(ctl_out), int'(exp_q));
      else
        check(tag, int'(ctl_out), m_sync ? int'(exp_q) : 0);
      if (m_sync)
        check("R6", int'(rd_addr), addr_of(next_of(m_pos, frame_pulse)));
    end
  end

  task automatic run(int n, int flip_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      if (flip_pct > 0 && ($urandom % 100) < flip_pct)
        mem[$urandom % SLOTS] = 1'($urandom);
    end
  endtask

  task automatic pulse();
    @(posedge clk);
    #2 frame_pulse = 1'b1;
    @(posedge clk);
    #2 frame_pulse = 1'b0;
  endtask

  task automatic fill(int mode);
    for (int a = 0; a < SLOTS; a++)
      mem[a] = (mode == 2) ? 1'($urandom) : 1'(mode);
  endtask

  task automatic reset_phase();
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check("R7", int'(ctl_out), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", int'(ctl_out), 0);
    end
    @(posedge clk);
    #2 rst_n = 1'b1;
    tag = "R7";
    run(6, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    compared = 0; mismatched = 0; done = 1'b0; mon_on = 1'b0;
    tag = "R7";
    frame_pulse = 1'b0;
    fill(1);
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #1 check("R7", int'(ctl_out), 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    mon_on = 1'b1;
    run(6, 0);  // all-ones memory, not yet aligned: line must stay low (R7)

    // R3: random contents with random changes
    fill(2);
    tag = "R3";
    pulse();
    run(2 * SLOTS, 30);

    // R2: polarity with all-ones then all-zeros memory
    tag = "R2";
    fill(1); run(SLOTS, 0);
    fill(0); run(SLOTS, 0);

    // R4: markers at stream 0 / stream 1, channel 0
    tag = "R4";
    fill(0); mem[0] = 1'b1; mem[32] = 1'b1;
    pulse();
    run(SLOTS + 8, 0);

    // R1: free running over several frames without pulses
    tag = "R1";
    fill(2);
    run(3 * SLOTS, 10);

    // R5: realignment pulses at random points inside a frame
    tag = "R5";
    for (int k = 0; k < 6; k++) begin
      run(1 + ($urandom % 200), 20);
      pulse();
    end
    pulse(); pulse();  // back-to-back pulses
    run(SLOTS, 20);

    // R7: reset in mid-run, then quiet until the next pulse
    reset_phase();
    tag = "R3";
    fill(2);
    pulse();
    run(SLOTS, 20);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule